// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Condition Flags

This block is the combinational arithmetic and logic unit of an 8-bit accumulator processor. Each cycle the datapath presents an operation code, the accumulator value, a second operand and the current four-bit condition flag vector. The block returns a result byte, the next flag vector and a write-enable. The write-enable tells the register file whether the result should be stored in the destination. Operand fetch, instruction decode, the register file and memory are outside the block.

Each operation has its own rule for every flag. A flag may be forced low, forced high, computed from the operation, or passed through from the incoming vector. The half-carry flag is stored with the other flags so that a later decimal-adjust operation can correct a packed BCD byte after an addition or after a subtraction. Increment and decrement work on the second operand, so the same unit serves any destination register.

Top module: `acc_alu`

## Requirements
- R1: The flag vector is {Z,N,H,C} at bits 3..0. Add (op 0) and add-with-carry (op 1) return acc+opnd (+C for op 1) modulo 256 with write-enable 1. Z is set when the result is zero and N is 0. H is the carry out of bit 3 and C is the carry out of bit 7, and both include the incoming C for op 1.
- R2: Subtract (op 2) and subtract-with-carry (op 3) return acc-opnd (-C for op 3) modulo 256 with write-enable 1. Z is set on a zero result and N is 1. H is the borrow into bit 4 and C is the borrow out of bit 7.
- R3: Compare (op 7) produces the same flags as op 2 on the same inputs and drives write-enable 0.
- R4: AND (op 4) returns acc&opnd with write-enable 1. Z is computed, N=0, H=1 and C=0.
- R5: XOR (op 5) and OR (op 6) return acc^opnd and acc|opnd with write-enable 1. Z is computed and N, H and C are 0.
- R6: Increment (op 8) and decrement (op 9) return opnd+1 and opnd-1 modulo 256 with write-enable 1. Z is computed, N is 0 for op 8 and 1 for op 9, H is the nibble carry or borrow, and C keeps its incoming value.
- R7: Complement (op 11) returns ~acc with write-enable 1. N and H are set to 1 and Z and C are kept.
- R8: Set-carry (op 12) forces C to 1 and complement-carry (op 13) inverts C. Both clear N and H, keep Z and drive write-enable 0.
- R9: Decimal adjust (op 10) with incoming N=0 adds 0x06 when H=1 or the low nibble of acc is above 9. It adds 0x60 and sets C when C=1 or acc is above 0x99, and otherwise clears C.
- R10: Decimal adjust with incoming N=1 subtracts 0x06 when H=1 and 0x60 when C=1, and keeps C. For both directions Z is computed, N is kept, H is cleared and write-enable is 1.
- R11: Op codes 14 and 15 drive write-enable 0 and return the incoming flag vector unchanged.
- R12: When write-enable is 0 the result byte is unspecified and may not be used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand; the source of increment and decrement |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| res_o | output | 8 | Result byte |
| flags_o | output | 4 | Next flags {Z,N,H,C} |
| wr_en_o | output | 1 | Result should be written to the destination |

## Verification
The add, subtract and compare codes are swept over every operand pair with both carry-in values. This separates nibble-boundary carries from bit-7 carries and shows whether the carry-in feeds both. The logic, increment and decrement codes are swept over every operand pair with random untouched flags, which shows any leak of the incoming C or of the wrong N. Decimal adjust is run on every accumulator value under all sixteen flag vectors, and also after real BCD additions and subtractions that chain the flags, so that the add-side and subtract-side correction rules are told apart. The flag-only codes and the unused codes are swept over all values and flag vectors to show which flags they keep.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int OPW = 4;
  localparam int FW  = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_AND = 4'd4,  OP_XOR = 4'd5,  OP_OR  = 4'd6,  OP_CMP = 4'd7,
    OP_INC = 4'd8,  OP_DEC = 4'd9,  OP_DAA = 4'd10, OP_CPL = 4'd11,
    OP_SCF = 4'd12, OP_CCF = 4'd13
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          sub_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          half_o,
  output logic          carry_o
);
  localparam int NW = DW / 2;

  logic [DW-1:0] y_eff;
  logic          cin_eff;
  logic [NW:0]   lo_sum;
  logic [NW:0]   hi_sum;

  // subtraction as x + ~y + ~borrow; carries are inverted back into borrows
  assign y_eff   = sub_i ? ~y_i : y_i;
  assign cin_eff = sub_i ^ cin_i;
  assign lo_sum  = {1'b0, x_i[NW-1:0]} + {1'b0, y_eff[NW-1:0]} + {{NW{1'b0}}, cin_eff};
  assign hi_sum  = {1'b0, x_i[DW-1:NW]} + {1'b0, y_eff[DW-1:NW]} + {{NW{1'b0}}, lo_sum[NW]};
  assign sum_o   = {hi_sum[NW-1:0], lo_sum[NW-1:0]};
  assign half_o  = lo_sum[NW] ^ sub_i;
  assign carry_o = hi_sum[NW] ^ sub_i;

  logic [DW-1:0] cin_ext;
  logic [DW-1:0] full_ref;
  assign cin_ext  = {{(DW-1){1'b0}}, cin_i};
  assign full_ref = sub_i ? (x_i - y_i - cin_ext) : (x_i + y_i + cin_ext);

  always_comb begin
    if (!$isunknown({x_i, y_i, sub_i, cin_i})) begin
      p_split_sum_r1: assert (sum_o == full_ref)
        else $error("split adder disagrees with full-width sum");
    end
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [1:0]    sel_i,
  output logic [DW-1:0] res_o
);
  // sel: 0 and, 1 xor, 2 or
  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_comb begin
      case (sel_i)
        2'd0:    res_o[i] = a_i[i] & b_i[i];
        2'd1:    res_o[i] = a_i[i] ^ b_i[i];
        default: res_o[i] = a_i[i] | b_i[i];
      endcase
    end
  end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic          n_i,
  input  logic          h_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  localparam int NW = DW / 2;
  localparam logic [NW-1:0] NIB_MAX = NW'(9);
  localparam logic [DW-1:0] BYTE_MAX = {NIB_MAX, NIB_MAX};
  localparam logic [NW-1:0] FIX = NW'(6);

  logic          lo_fix;
  logic          hi_fix;
  logic [DW-1:0] corr;

  assign lo_fix = h_i | (!n_i && (a_i[NW-1:0] > NIB_MAX));
  assign hi_fix = c_i | (!n_i && (a_i > BYTE_MAX));
  assign corr   = {hi_fix ? FIX : '0, lo_fix ? FIX : '0};
  assign res_o  = n_i ? (a_i - corr) : (a_i + corr);
  assign c_o    = hi_fix;

  always_comb begin
    if (!$isunknown({a_i, n_i, h_i, c_i})) begin
      p_sub_keeps_c_r10: assert (!n_i || (c_o == c_i))
        else $error("decimal adjust after subtract changed carry");
      p_carry_set_sticks_r9: assert (!c_i || c_o)
        else $error("decimal adjust dropped an incoming carry");
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  opnd_i,
  input  logic [FW-1:0]  flags_i,
  output logic [DW-1:0]  res_o,
  output logic [FW-1:0]  flags_o,
  output logic           wr_en_o
);
  alu_flags_t    fin;
  alu_flags_t    fout;
  alu_op_e       op_e;

  logic [DW-1:0] as_x;
  logic [DW-1:0] as_y;
  logic          as_sub;
  logic          as_cin;
  logic [DW-1:0] as_sum;
  logic          as_half;
  logic          as_carry;
  logic [DW-1:0] lg_res;
  logic [DW-1:0] da_res;
  logic          da_c;

  assign fin     = alu_flags_t'(flags_i);
  assign op_e    = alu_op_e'(op_i);
  assign flags_o = fout;

  // one shared adder; increment and decrement reuse it on the second operand
  always_comb begin
    as_x   = acc_i;
    as_y   = opnd_i;
    as_sub = 1'b0;
    as_cin = 1'b0;
    case (op_e)
      OP_ADC:         as_cin = fin.c;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBC: begin
        as_sub = 1'b1;
        as_cin = fin.c;
      end
      OP_INC: begin
        as_x = opnd_i;
        as_y = DW'(1);
      end
      OP_DEC: begin
        as_x   = opnd_i;
        as_y   = DW'(1);
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  acc_alu_addsub #(.DW(DW)) u_addsub (
    .x_i     (as_x),
    .y_i     (as_y),
    .sub_i   (as_sub),
    .cin_i   (as_cin),
    .sum_o   (as_sum),
    .half_o  (as_half),
    .carry_o (as_carry)
  );

  acc_alu_logic #(.DW(DW)) u_logic (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sel_i (op_i[1:0]),
    .res_o (lg_res)
  );

  acc_alu_decadj #(.DW(DW)) u_decadj (
    .a_i   (acc_i),
    .n_i   (fin.n),
    .h_i   (fin.h),
    .c_i   (fin.c),
    .res_o (da_res),
    .c_o   (da_c)
  );

  always_comb begin
    res_o   = acc_i;
    fout    = fin;
    wr_en_o = 1'b0;
    case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
        res_o   = as_sum;
        fout    = '{z: (as_sum == '0), n: as_sub, h: as_half, c: as_carry};
        wr_en_o = (op_e != OP_CMP);
      end
      OP_AND, OP_XOR, OP_OR: begin
        res_o   = lg_res;
        fout    = '{z: (lg_res == '0), n: 1'b0, h: (op_e == OP_AND), c: 1'b0};
        wr_en_o = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res_o   = as_sum;
        fout    = '{z: (as_sum == '0), n: as_sub, h: as_half, c: fin.c};
        wr_en_o = 1'b1;
      end
      OP_DAA: begin
        res_o   = da_res;
        fout    = '{z: (da_res == '0), n: fin.n, h: 1'b0, c: da_c};
        wr_en_o = 1'b1;
      end
      OP_CPL: begin
        res_o   = ~acc_i;
        fout.n  = 1'b1;
        fout.h  = 1'b1;
        wr_en_o = 1'b1;
      end
      OP_SCF: fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: 1'b1};
      OP_CCF: fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: ~fin.c};
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, acc_i, opnd_i, flags_i})) begin
      p_cmp_no_write_r3: assert (op_i != 4'd7 || !wr_en_o)
        else $error("compare requested a write");
      p_logic_no_carry_r4: assert (!(op_i inside {4'd4, 4'd5, 4'd6}) || (!flags_o[0] && !flags_o[2]))
        else $error("logic op left N or C set");
      p_incdec_keep_c_r6: assert (!(op_i inside {4'd8, 4'd9}) || (flags_o[0] == flags_i[0]))
        else $error("increment/decrement touched carry");
      p_cpl_keep_zc_r7: assert (op_i != 4'd11 || (flags_o[3] == flags_i[3] && flags_o[0] == flags_i[0]))
        else $error("complement touched Z or C");
      p_carry_ops_r8: assert (!(op_i inside {4'd12, 4'd13}) || (!wr_en_o && flags_o[3] == flags_i[3]))
        else $error("carry op wrote or changed Z");
      p_unused_idle_r11: assert (!(op_i inside {4'd14, 4'd15}) || (!wr_en_o && flags_o == flags_i))
        else $error("unused op code had an effect");
    end
  end
endmodule

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;
  logic       clk = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] acc = 8'd0;
  logic [7:0] opnd = 8'd0;
  logic [3:0] flg = 4'd0;
  logic [7:0] res;
  logic [3:0] flg_out;
  logic       wr_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  acc_alu dut (
    .op_i    (op),
    .acc_i   (acc),
    .opnd_i  (opnd),
    .flags_i (flg),
    .res_o   (res),
    .flags_o (flg_out),
    .wr_en_o (wr_en)
  );

  // {wr, res[7:0], z, n, h, c}
  function automatic logic [12:0] model(int o, int a, int b, logic [3:0] f);
    logic z, n, h, c, w;
    int   r, ci, lo_fix, hi_fix;
    z = f[3]; n = f[2]; h = f[1]; c = f[0]; w = 1'b0; r = 0;
    case (o)
      0, 1: begin
        ci = (o == 1) ? int'(c) : 0;
        r = a + b + ci;
        h = ((a & 15) + (b & 15) + ci) > 15;
        c = r > 255; r = r & 255; n = 0; z = (r == 0); w = 1;
      end
      2, 3, 7: begin
        ci = (o == 3) ? int'(c) : 0;
        r = a - b - ci;
        h = ((a & 15) - (b & 15) - ci) < 0;
        c = r < 0; r = r & 255; n = 1; z = (r == 0); w = (o != 7);
      end
      4: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; w = 1; end
      5: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; w = 1; end
      6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; w = 1; end
      8: begin r = (b + 1) & 255; h = (b & 15) == 15; n = 0; z = (r == 0); w = 1; end
      9: begin r = (b - 1) & 255; h = (b & 15) == 0; n = 1; z = (r == 0); w = 1; end
      10: begin
        r = a;
        if (!n) begin
          lo_fix = (h || (a & 15) > 9) ? 6 : 0;
          hi_fix = (c || a > 153) ? 96 : 0;
          c = (hi_fix != 0);
          r = (a + lo_fix + hi_fix) & 255;
        end else begin
          if (h) r = r - 6;
          if (c) r = r - 96;
          r = r & 255;
        end
        z = (r == 0); h = 0; w = 1;
      end
      11: begin r = (~a) & 255; n = 1; h = 1; w = 1; end
      12: begin c = 1; n = 0; h = 0; end
      13: begin c = ~c; n = 0; h = 0; end
      default: ;
    endcase
    return {w, 8'(r), z, n, h, c};
  endfunction

  function automatic string req_of(int o, logic nin);
    case (o)
      0, 1:    return "R1";
      2, 3:    return "R2";
      7:       return "R3";
      4:       return "R4";
      5, 6:    return "R5";
      8, 9:    return "R6";
      10:      return nin ? "R10" : "R9";
      11:      return "R7";
      12, 13:  return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(int o, int a, int b, logic [3:0] f, output logic [12:0] got);
    logic [12:0] exp;
    logic        ok;
    op = 4'(o); acc = 8'(a); opnd = 8'(b); flg = f;
    #0.5;
    exp = model(o, a, b, f);
    got = {wr_en, res, flg_out};
    ok  = (got[12] == exp[12]) && (got[3:0] == exp[3:0]);
    if (exp[12]) ok = ok && (got[11:4] == exp[11:4]); // R12: result ignored when not written
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%b: got wr=%b res=%02h flags=%b, expected wr=%b res=%02h flags=%b",
               req_of(o, f[2]), o, a, b, f, got[12], got[11:4], got[3:0], exp[12], exp[11:4], exp[3:0]);
    end
  endtask

  initial begin
    logic [12:0] g;
    logic [12:0] g2;
    void'($urandom(32'd4242));
    #1;
    // idle inputs: add 0+0 gives zero result, Z set (R1)
    apply(0, 0, 0, 4'b0000, g);

    // R1 R2 R3: every operand pair, both carry-in values, random other flags
    for (int o = 0; o < 8; o++) begin
      if (o inside {0, 1, 2, 3, 7}) begin
        for (int a = 0; a < 256; a++)
          for (int b = 0; b < 256; b++)
            for (int ci = 0; ci < 2; ci++)
              apply(o, a, b, {3'($urandom), 1'(ci)}, g);
      end
    end

    // R4 R5 R6: every operand pair, random incoming flags
    for (int o = 4; o < 10; o++) begin
      if (o != 7) begin
        for (int a = 0; a < 256; a++)
          for (int b = 0; b < 256; b++)
            apply(o, a, b, 4'($urandom), g);
      end
    end

    // R9 R10 R7 R8 R11: every accumulator value under every flag vector
    for (int o = 10; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int f = 0; f < 16; f++)
          apply(o, a, int'($urandom % 256), 4'(f), g);

    // R9: chained BCD additions, 15+27=42, 99+01=00 carry, 58+46=104
    apply(0, 8'h15, 8'h27, 4'b0000, g);  apply(10, int'(g[11:4]), 0, g[3:0], g2);
    apply(0, 8'h99, 8'h01, 4'b0000, g);  apply(10, int'(g[11:4]), 0, g[3:0], g2);
    apply(0, 8'h58, 8'h46, 4'b0000, g);  apply(10, int'(g[11:4]), 0, g[3:0], g2);
    // R10: chained BCD subtractions, 42-15=27, 10-20 borrows
    apply(2, 8'h42, 8'h15, 4'b0000, g);  apply(10, int'(g[11:4]), 0, g[3:0], g2);
    apply(2, 8'h10, 8'h20, 4'b0000, g);  apply(10, int'(g[11:4]), 0, g[3:0], g2);

    // random mix over all op codes
    for (int i = 0; i < 4000; i++)
      apply(int'($urandom % 16), int'($urandom % 256), int'($urandom % 256), 4'($urandom), g);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #950000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule